// File: doc/BRIEF.md
# PCI Address Window Translator

This block sits between a local bus master and a PCI initiator. A local read or write whose address falls in the upper-middle quarter of the 32-bit space (bits 31:30 equal to 2'b10) becomes one abstract PCI request. The request carries a command, an address, byte enables and write data. Every other local address completes at once with an error and no bus cycle. A sticky mode bit in the control register picks the cycle type. In memory mode the low 30 address bits pass through and the two top bits come from the control register. In configuration mode the local address is split into device, function and register offset. These fields are rebuilt into a type-0 configuration address whose IDSEL line is one-hot.

Configuration targets whose IDSEL line would fall outside the 1 MiB configuration window are refused before any bus cycle. So are device numbers above the legal maximum. A sub-word configuration write becomes a read of the whole word followed by a write of the merged word. A master abort ends the request with an error, returns all ones on a read and sets a sticky flag that software clears. The same control register also sets the drive mode of the PCI reset pin. The local port allows one outstanding request: it holds ready low until the PCI side reports completion or abort.

Top module: `pciw_window_top`

## Requirements
- R1: A PCI request is raised only for local addresses with bits 31:30 equal to 2'b10. Any other address completes with rsp_err_o=1 and rsp_rdata_o=32'hFFFF_FFFF, and pci_req_o stays low.
- R2: With control bit 1 clear (memory mode), pci_addr_o is {control bits 3:2, local address bits 29:0}. The command is 4'h6 for a read and 4'h7 for a write.
- R3: With control bit 1 set (configuration mode), local address bits 15:11 are the device, bits 10:8 the function and bits 7:0 the offset. pci_addr_o is (1 << (13+device)) OR (function << 8) OR (offset with bits 1:0 cleared). The command is 4'hA for a read and 4'hB for a write, and pci_be_o is 4'hF.
- R4: A configuration request is not issued when its IDSEL bit would lie at address bit 20 or above (device greater than 6), or when its device exceeds 18. It completes with rsp_err_o=1 and rsp_rdata_o=32'hFFFF_FFFF.
- R5: req_size_i codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. The selected lanes are the size mask shifted left by address bits 1:0. In memory mode pci_be_o equals these lanes and pci_wdata_o is the write data shifted left by 8*addr[1:0]. In both modes read data returns as the PCI word masked to the lanes and shifted right by 8*addr[1:0].
- R6: A configuration write of size code 0 or 1 issues a configuration read at the same address first. It then issues a configuration write of the read word with the selected lanes replaced by the shifted write data. An abort on the read phase ends the request without the write.
- R7: pci_abort_i during a request ends it with rsp_err_o=1 and, for reads, rsp_rdata_o=32'hFFFF_FFFF. It also sets abort_flag_o. The flag stays set until a status write (reg_sel_i=1) with bit 26 set; a status write with bit 26 clear leaves it.
- R8: Control bits 5:4 set the reset pin. 0 and 3 give rst_pin_oe_o=0. 1 gives rst_pin_oe_o=1 with rst_pin_o=0, and 2 gives rst_pin_oe_o=1 with rst_pin_o=1. A control write (reg_sel_i=0) replaces all control fields.
- R9: pci_req_o and its command, address, enables and data hold steady until pci_done_i or pci_abort_i. req_ready_o is high for exactly one cycle, the cycle after the completing done or abort (or after acceptance for a refused request), and never together with pci_req_o.
- R10: After reset the block is in memory mode, the upper address bits are 0, the reset pin is an input, abort_flag_o is clear, and pci_req_o and req_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Local request valid, held until ready |
| req_addr_i | input | 32 | Local byte address |
| req_we_i | input | 1 | Local write when high |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Local write data, lane-0 aligned |
| req_ready_o | output | 1 | One-cycle completion of the local request |
| rsp_rdata_o | output | 32 | Read data, valid with ready |
| rsp_err_o | output | 1 | Request refused or aborted, valid with ready |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control, 1 selects status |
| reg_wdata_i | input | 32 | Register write data |
| abort_flag_o | output | 1 | Sticky master-abort flag |
| rst_pin_o | output | 1 | PCI reset pin output level |
| rst_pin_oe_o | output | 1 | PCI reset pin output enable |
| pci_req_o | output | 1 | PCI request pending |
| pci_cmd_o | output | 4 | PCI command code |
| pci_addr_o | output | 32 | PCI address |
| pci_be_o | output | 4 | Byte enables, active high |
| pci_wdata_o | output | 32 | PCI write data |
| pci_done_i | input | 1 | PCI cycle completed |
| pci_abort_i | input | 1 | PCI cycle ended by master abort |
| pci_rdata_i | input | 32 | PCI read data, valid with done |

## Verification
The assertions check on every cycle that commands stay legal and that a pending request holds still until it ends. They also check that ready and request never overlap, that an abort always sets the sticky flag, and that every configuration address carries exactly one IDSEL bit inside the 1 MiB window. Only the bench scenarios can show the arithmetic of the translation. That covers the memory address splice, the byte-lane masks and data shifts for every size and offset, and the refusal boundary between device 6 and device 7. It also covers the contents of the merged word in a read-modify-write and the all-ones data on refused and aborted reads.

// File: rtl/pciw_pkg.sv
package pciw_pkg;
  typedef enum logic [3:0] {
    CMD_MEM_RD = 4'h6,
    CMD_MEM_WR = 4'h7,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } pci_cmd_e;

  typedef enum logic [1:0] {
    PIN_HIZ  = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_RSVD = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUS  = 2'd1,
    S_RESP = 2'd2
  } seq_state_e;

  localparam int CTL_CFG_BIT   = 1;
  localparam int CTL_HI_LSB    = 2;
  localparam int CTL_PIN_LSB   = 4;
  localparam int STAT_ABORT_BIT = 26;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [3:0] size_lanes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pciw_regs.sv
module pciw_regs
  import pciw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic       abort_evt_i,
  output logic       cfg_mode_o,
  output logic [1:0] hi_bits_o,
  output logic       abort_flag_o,
  output logic       rst_pin_o,
  output logic       rst_pin_oe_o
);
  logic      cfg_mode_q;
  logic [1:0] hi_q;
  pin_mode_e pin_q;
  logic      abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode_q <= 1'b0;
      hi_q       <= 2'd0;
      pin_q      <= PIN_HIZ;
      abort_q    <= 1'b0;
    end else begin
      if (reg_we_i && !reg_sel_i) begin
        cfg_mode_q <= reg_wdata_i[CTL_CFG_BIT];
        hi_q       <= reg_wdata_i[CTL_HI_LSB +: 2];
        pin_q      <= pin_mode_e'(reg_wdata_i[CTL_PIN_LSB +: 2]);
      end
      // a new abort wins over a clear in the same cycle
      if (abort_evt_i)
        abort_q <= 1'b1;
      else if (reg_we_i && reg_sel_i && reg_wdata_i[STAT_ABORT_BIT])
        abort_q <= 1'b0;
    end
  end

  assign cfg_mode_o   = cfg_mode_q;
  assign hi_bits_o    = hi_q;
  assign abort_flag_o = abort_q;
  assign rst_pin_oe_o = (pin_q == PIN_LOW) || (pin_q == PIN_HIGH);
  assign rst_pin_o    = (pin_q == PIN_HIGH);
endmodule

// File: rtl/pciw_xlate.sv
module pciw_xlate
  import pciw_pkg::*;
#(
  parameter int IDSEL_BASE    = 13,
  parameter int MAX_DEV       = 18,
  parameter int CFG_SPAN_LOG2 = 20
) (
  input  logic [31:0] addr_i,
  input  logic [1:0]  size_i,
  input  logic        cfg_mode_i,
  input  logic [1:0]  hi_bits_i,
  output logic        in_window_o,
  output logic        cfg_ok_o,
  output logic [31:0] pci_addr_o,
  output logic [3:0]  lanes_o
);
  localparam int DEV_W  = 5;
  localparam int WIDE_W = 64;

  logic [DEV_W-1:0]  dev;
  logic [2:0]        func;
  logic [5:0]        off_word;
  logic [6:0]        sel_pos;
  logic [WIDE_W-1:0] idsel_w;
  logic [31:0]       cfg_addr;
  logic [31:0]       mem_addr;

  assign dev      = addr_i[15:11];
  assign func     = addr_i[10:8];
  assign off_word = addr_i[7:2];
  assign sel_pos  = 7'(IDSEL_BASE) + {2'b00, dev};
  assign idsel_w  = WIDE_W'(1) << sel_pos;

  assign in_window_o = (addr_i[31:30] == 2'b10);
  assign cfg_ok_o    = (int'({27'd0, dev}) <= MAX_DEV) &&
                       (idsel_w[WIDE_W-1:CFG_SPAN_LOG2] == '0);

  assign cfg_addr   = idsel_w[31:0] | {21'd0, func, 8'd0} | {24'd0, off_word, 2'b00};
  assign mem_addr   = {hi_bits_i, addr_i[29:0]};
  assign pci_addr_o = cfg_mode_i ? cfg_addr : mem_addr;
  assign lanes_o    = size_lanes(size_i) << addr_i[1:0];
endmodule

// File: rtl/pciw_seq.sv
module pciw_seq
  import pciw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [1:0]        req_lane_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              in_window_i,
  input  logic              cfg_mode_i,
  input  logic              cfg_ok_i,
  input  logic [31:0]       x_addr_i,
  input  logic [3:0]        x_lanes_i,
  input  logic              pci_done_i,
  input  logic              pci_abort_i,
  input  logic [DATA_W-1:0] pci_rdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              abort_evt_o,
  output logic              pci_req_o,
  output logic [3:0]        pci_cmd_o,
  output logic [31:0]       pci_addr_o,
  output logic [3:0]        pci_be_o,
  output logic [DATA_W-1:0] pci_wdata_o
);
  localparam int LANES = DATA_W / 8;
  localparam int SH_W  = $clog2(DATA_W);

  seq_state_e        st_q;
  pci_cmd_e          cmd_q;
  logic [31:0]       addr_q;
  logic [LANES-1:0]  lanes_q;
  logic [SH_W-1:0]   sh_q;
  logic [DATA_W-1:0] wsh_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              cfg_q;
  logic              rmw_q;

  logic [DATA_W-1:0] byte_mask;
  logic [DATA_W-1:0] merged;
  logic [SH_W-1:0]   req_sh;

  assign req_sh = SH_W'({req_lane_i, 3'b000});

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_mask[8*g +: 8] = {8{lanes_q[g]}};
    assign merged[8*g +: 8]    = lanes_q[g] ? wsh_q[8*g +: 8] : pci_rdata_i[8*g +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cmd_q   <= CMD_MEM_RD;
      addr_q  <= '0;
      lanes_q <= '0;
      sh_q    <= '0;
      wsh_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      cfg_q   <= 1'b0;
      rmw_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (req_valid_i) begin
            if (!in_window_i || (cfg_mode_i && !cfg_ok_i)) begin
              err_q   <= 1'b1;
              rdata_q <= '1;
              st_q    <= S_RESP;
            end else begin
              err_q   <= 1'b0;
              addr_q  <= x_addr_i;
              lanes_q <= x_lanes_i;
              sh_q    <= req_sh;
              wsh_q   <= req_wdata_i << req_sh;
              cfg_q   <= cfg_mode_i;
              rmw_q   <= cfg_mode_i && req_we_i && (req_size_i < SZ_WORD);
              if (cfg_mode_i)
                cmd_q <= (req_we_i && (req_size_i >= SZ_WORD)) ? CMD_CFG_WR : CMD_CFG_RD;
              else
                cmd_q <= req_we_i ? CMD_MEM_WR : CMD_MEM_RD;
              st_q    <= S_BUS;
            end
          end
        end
        S_BUS: begin
          if (pci_abort_i) begin
            err_q   <= 1'b1;
            rdata_q <= '1;
            rmw_q   <= 1'b0;
            st_q    <= S_RESP;
          end else if (pci_done_i) begin
            if (rmw_q) begin
              // second phase: write back the merged word, request stays up
              wsh_q <= merged;
              rmw_q <= 1'b0;
              cmd_q <= CMD_CFG_WR;
            end else begin
              rdata_q <= (pci_rdata_i & byte_mask) >> sh_q;
              st_q    <= S_RESP;
            end
          end
        end
        S_RESP:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign pci_req_o   = (st_q == S_BUS);
  assign req_ready_o = (st_q == S_RESP);
  assign abort_evt_o = pci_req_o && pci_abort_i;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
  assign pci_cmd_o   = cmd_q;
  assign pci_addr_o  = addr_q;
  assign pci_be_o    = cfg_q ? 4'hF : lanes_q;
  assign pci_wdata_o = wsh_q;
endmodule

// File: rtl/pciw_window_top.sv
module pciw_window_top
  import pciw_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int IDSEL_BASE    = 13,
  parameter int MAX_DEV       = 18,
  parameter int CFG_SPAN_LOG2 = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              abort_flag_o,
  output logic              rst_pin_o,
  output logic              rst_pin_oe_o,
  output logic              pci_req_o,
  output logic [3:0]        pci_cmd_o,
  output logic [31:0]       pci_addr_o,
  output logic [3:0]        pci_be_o,
  output logic [DATA_W-1:0] pci_wdata_o,
  input  logic              pci_done_i,
  input  logic              pci_abort_i,
  input  logic [DATA_W-1:0] pci_rdata_i
);
  logic        cfg_mode;
  logic [1:0]  hi_bits;
  logic        abort_evt;
  logic        in_window;
  logic        cfg_ok;
  logic [31:0] x_addr;
  logic [3:0]  x_lanes;

  pciw_regs i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .abort_evt_i  (abort_evt),
    .cfg_mode_o   (cfg_mode),
    .hi_bits_o    (hi_bits),
    .abort_flag_o (abort_flag_o),
    .rst_pin_o    (rst_pin_o),
    .rst_pin_oe_o (rst_pin_oe_o)
  );

  pciw_xlate #(
    .IDSEL_BASE    (IDSEL_BASE),
    .MAX_DEV       (MAX_DEV),
    .CFG_SPAN_LOG2 (CFG_SPAN_LOG2)
  ) i_xlate (
    .addr_i      (req_addr_i),
    .size_i      (req_size_i),
    .cfg_mode_i  (cfg_mode),
    .hi_bits_i   (hi_bits),
    .in_window_o (in_window),
    .cfg_ok_o    (cfg_ok),
    .pci_addr_o  (x_addr),
    .lanes_o     (x_lanes)
  );

  pciw_seq #(.DATA_W(DATA_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_size_i  (req_size_i),
    .req_lane_i  (req_addr_i[1:0]),
    .req_wdata_i (req_wdata_i),
    .in_window_i (in_window),
    .cfg_mode_i  (cfg_mode),
    .cfg_ok_i    (cfg_ok),
    .x_addr_i    (x_addr),
    .x_lanes_i   (x_lanes),
    .pci_done_i  (pci_done_i),
    .pci_abort_i (pci_abort_i),
    .pci_rdata_i (pci_rdata_i),
    .req_ready_o (req_ready_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o),
    .abort_evt_o (abort_evt),
    .pci_req_o   (pci_req_o),
    .pci_cmd_o   (pci_cmd_o),
    .pci_addr_o  (pci_addr_o),
    .pci_be_o    (pci_be_o),
    .pci_wdata_o (pci_wdata_o)
  );
endmodule

// File: rtl/pciw_window_chk.sv
module pciw_window_chk #(
  parameter int IDSEL_BASE    = 13,
  parameter int CFG_SPAN_LOG2 = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  win_bits_i,
  input logic        req_ready_o,
  input logic        reg_we_i,
  input logic        reg_sel_i,
  input logic [1:0]  ctl_pin_i,
  input logic        abort_clr_i,
  input logic        abort_flag_o,
  input logic        rst_pin_o,
  input logic        rst_pin_oe_o,
  input logic        pci_req_o,
  input logic [3:0]  pci_cmd_o,
  input logic [31:0] pci_addr_o,
  input logic [3:0]  pci_be_o,
  input logic [31:0] pci_wdata_o,
  input logic        pci_done_i,
  input logic        pci_abort_i
);
  p_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_req_o) |-> $past(win_bits_i) == 2'b10);

  p_cmd_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o |-> (pci_cmd_o == 4'h6 || pci_cmd_o == 4'h7 ||
                   pci_cmd_o == 4'hA || pci_cmd_o == 4'hB));

  p_cfg_idsel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_o && pci_cmd_o[3]) |->
      (pci_addr_o[31:CFG_SPAN_LOG2] == '0) &&
      ($countones(pci_addr_o[CFG_SPAN_LOG2-1:IDSEL_BASE]) == 1) &&
      (pci_addr_o[IDSEL_BASE-1:11] == '0) && (pci_be_o == 4'hF));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_o && !pci_done_i && !pci_abort_i) |=>
      pci_req_o && $stable(pci_cmd_o) && $stable(pci_addr_o) &&
      $stable(pci_be_o) && $stable(pci_wdata_o));

  p_ready_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !pci_req_o);

  p_ready_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  p_abort_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_o && pci_abort_i) |=> abort_flag_o);

  p_abort_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_flag_o && !(reg_we_i && reg_sel_i && abort_clr_i)) |=> abort_flag_o);

  p_pin_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i && ctl_pin_i == 2'd1) |=> (rst_pin_oe_o && !rst_pin_o));

  p_pin_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i && ctl_pin_i == 2'd2) |=> (rst_pin_oe_o && rst_pin_o));

  p_pin_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i && (ctl_pin_i == 2'd0 || ctl_pin_i == 2'd3)) |=> !rst_pin_oe_o);
endmodule

bind pciw_window_top pciw_window_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_bits_i   (req_addr_i[31:30]),
  .req_ready_o  (req_ready_o),
  .reg_we_i     (reg_we_i),
  .reg_sel_i    (reg_sel_i),
  .ctl_pin_i    (reg_wdata_i[5:4]),
  .abort_clr_i  (reg_wdata_i[26]),
  .abort_flag_o (abort_flag_o),
  .rst_pin_o    (rst_pin_o),
  .rst_pin_oe_o (rst_pin_oe_o),
  .pci_req_o    (pci_req_o),
  .pci_cmd_o    (pci_cmd_o),
  .pci_addr_o   (pci_addr_o),
  .pci_be_o     (pci_be_o),
  .pci_wdata_o  (pci_wdata_o),
  .pci_done_i   (pci_done_i),
  .pci_abort_i  (pci_abort_i)
);

// File: tb/test_pciw_window_top.sv
`timescale 1ns/1ps
module test_pciw_window_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        abort_flag;
  logic        rst_pin;
  logic        rst_pin_oe;
  logic        pci_req;
  logic [3:0]  pci_cmd;
  logic [31:0] pci_addr;
  logic [3:0]  pci_be;
  logic [31:0] pci_wdata;
  logic        pci_done = 1'b0;
  logic        pci_abort = 1'b0;
  logic [31:0] pci_rdata = '0;

  always #4 clk = ~clk;

  pciw_window_top i_pciw_window_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .req_we_i     (req_we),
    .req_size_i   (req_size),
    .req_wdata_i  (req_wdata),
    .req_ready_o  (req_ready),
    .rsp_rdata_o  (rsp_rdata),
    .rsp_err_o    (rsp_err),
    .reg_we_i     (reg_we),
    .reg_sel_i    (reg_sel),
    .reg_wdata_i  (reg_wdata),
    .abort_flag_o (abort_flag),
    .rst_pin_o    (rst_pin),
    .rst_pin_oe_o (rst_pin_oe),
    .pci_req_o    (pci_req),
    .pci_cmd_o    (pci_cmd),
    .pci_addr_o   (pci_addr),
    .pci_be_o     (pci_be),
    .pci_wdata_o  (pci_wdata),
    .pci_done_i   (pci_done),
    .pci_abort_i  (pci_abort),
    .pci_rdata_i  (pci_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  // transaction log filled by the responder in run_req
  int          n_txn;
  logic [3:0]  t_cmd   [2];
  logic [31:0] t_addr  [2];
  logic [3:0]  t_be    [2];
  logic [31:0] t_wdata [2];
  logic [31:0] r_data;
  logic        r_err;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] resp_of(input logic [31:0] a);
    return a ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] ln);
    logic [3:0] m;
    m = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
    return m << ln;
  endfunction

  function automatic logic [31:0] bmask(input logic [3:0] l);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{l[i]}};
    return m;
  endfunction

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  // drives one local request and answers PCI cycles after dly wait cycles;
  // the PCI cycle with index abort_at is aborted (-1: none)
  task automatic run_req(input logic [31:0] a, input logic we, input logic [31:0] wd,
                         input logic [1:0] sz, input int dly, input int abort_at);
    bit got = 0;
    int wcnt = 0;
    n_txn = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd; req_size = sz;
    for (int cyc = 0; cyc < 60 && !got; cyc++) begin
      @(negedge clk);
      pci_done = 1'b0; pci_abort = 1'b0;
      if (req_ready) begin
        r_data = rsp_rdata; r_err = rsp_err; got = 1;
        chk("R9 ready without request", {31'd0, pci_req}, 32'd0);
        req_valid = 1'b0;
      end else if (pci_req) begin
        if (wcnt == 0) begin
          if (n_txn < 2) begin
            t_cmd[n_txn] = pci_cmd; t_addr[n_txn] = pci_addr;
            t_be[n_txn] = pci_be; t_wdata[n_txn] = pci_wdata;
          end
        end else if (n_txn < 2) begin
          chk("R9 held address", pci_addr, t_addr[n_txn]);
          chk("R9 held command", {28'd0, pci_cmd}, {28'd0, t_cmd[n_txn]});
        end
        if (wcnt >= dly) begin
          if (n_txn == abort_at) pci_abort = 1'b1;
          else begin pci_done = 1'b1; pci_rdata = resp_of(pci_addr); end
          n_txn++;
          wcnt = 0;
        end else wcnt++;
      end
    end
    if (!got) begin
      n_err++; n_chk++;
      $display("FAIL R9 request hung actual=%h expected=ready", a);
    end
    @(negedge clk);
    chk("R9 ready one cycle", {31'd0, req_ready}, 32'd0);
    chk("R9 no request after completion", {31'd0, pci_req}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] a, ea, er, ew, m;
    logic [3:0]  ln;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 ready", {31'd0, req_ready}, 32'd0);
    chk("R10 pci_req", {31'd0, pci_req}, 32'd0);
    chk("R10 pin oe", {31'd0, rst_pin_oe}, 32'd0);
    chk("R10 abort flag", {31'd0, abort_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 pin oe after release", {31'd0, rst_pin_oe}, 32'd0);
    run_req(32'h9234_5678, 1'b0, '0, 2'd2, 0, -1);
    chk("R10 memory mode cmd", {28'd0, t_cmd[0]}, 32'h6);
    chk("R10 upper bits zero", t_addr[0], 32'h1234_5678);

    // R2 R5: memory sweep over upper bits, sizes, lanes, direction
    for (int hi = 0; hi < 4; hi++) begin
      reg_wr(1'b0, 32'(hi) << 2);
      for (int sz = 0; sz < 3; sz++) begin
        for (int l = 0; l < 4; l++) begin
          if ((sz == 1 && l[0]) || (sz == 2 && l != 0)) continue;
          for (int w = 0; w < 2; w++) begin
            a  = 32'h8000_0000 | ((32'h0135_79B0 * 32'(hi + 3 * sz + 1)) & 32'h3FFF_FFFC) | 32'(l);
            ea = {2'(hi), a[29:0]};
            ln = exp_lanes(2'(sz), 2'(l));
            run_req(a, w[0], 32'hC3A5_1E69 + 32'(l), 2'(sz), l % 2, -1);
            chk("R1 one cycle in window", 32'(n_txn), 32'd1);
            chk("R2 memory command", {28'd0, t_cmd[0]}, w[0] ? 32'h7 : 32'h6);
            chk("R2 memory address", t_addr[0], ea);
            chk("R5 memory lanes", {28'd0, t_be[0]}, {28'd0, ln});
            chk("R5 error clear", {31'd0, r_err}, 32'd0);
            if (w[0]) chk("R5 shifted write data", t_wdata[0], (32'hC3A5_1E69 + 32'(l)) << (8 * l));
            else chk("R5 read data", r_data, (resp_of(ea) & bmask(ln)) >> (8 * l));
          end
        end
      end
    end

    // R1: out-of-window addresses in both modes
    for (int md = 0; md < 2; md++) begin
      reg_wr(1'b0, 32'(md) << 1);
      foreach (a[i]) begin end
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: a = 32'h0000_1000;
          1: a = 32'h7FFF_FFFC;
          2: a = 32'hC000_0000;
          default: a = 32'hFFFF_FFF0;
        endcase
        run_req(a, 1'(k), 32'h1111_2222, 2'd2, 0, -1);
        chk("R1 no PCI cycle outside window", 32'(n_txn), 32'd0);
        chk("R1 error outside window", {31'd0, r_err}, 32'd1);
        chk("R1 all ones outside window", r_data, 32'hFFFF_FFFF);
      end
    end

    // R3 R4: configuration reads over devices, functions, offsets
    reg_wr(1'b0, 32'h0000_0002);
    for (int dv = 0; dv < 22; dv++) begin
      for (int fk = 0; fk < 3; fk++) begin
        for (int ok = 0; ok < 3; ok++) begin
          logic [2:0] fn;
          logic [7:0] off;
          logic [1:0] sz;
          fn  = (fk == 0) ? 3'd0 : (fk == 1) ? 3'd3 : 3'd7;
          off = (ok == 0) ? 8'h00 : (ok == 1) ? 8'h3D : 8'hEE;
          sz  = (ok == 0) ? 2'd2 : (ok == 1) ? 2'd0 : 2'd1;
          a = 32'h8000_0000 | (32'(dv) << 11) | (32'(fn) << 8) | 32'(off);
          run_req(a, 1'b0, '0, sz, 0, -1);
          if (dv <= 6) begin
            ea = (32'd1 << (13 + dv)) | (32'(fn) << 8) | 32'(off & 8'hFC);
            ln = exp_lanes(sz, off[1:0]);
            chk("R3 config cycle issued", 32'(n_txn), 32'd1);
            chk("R3 config read command", {28'd0, t_cmd[0]}, 32'hA);
            chk("R3 config address", t_addr[0], ea);
            chk("R3 config enables", {28'd0, t_be[0]}, 32'hF);
            chk("R5 config read data", r_data, (resp_of(ea) & bmask(ln)) >> (8 * off[1:0]));
          end else begin
            chk("R4 refused target not issued", 32'(n_txn), 32'd0);
            chk("R4 refused target error", {31'd0, r_err}, 32'd1);
            chk("R4 refused target all ones", r_data, 32'hFFFF_FFFF);
          end
        end
      end
    end

    // R3 R6: configuration writes, full word and read-modify-write
    for (int dv = 0; dv < 7; dv++) begin
      for (int sz = 0; sz < 3; sz++) begin
        logic [7:0] off;
        off = (sz == 0) ? 8'h13 : (sz == 1) ? 8'h22 : 8'h40;
        a  = 32'h8000_0000 | (32'(dv) << 11) | (32'(dv) << 8) | 32'(off);
        ea = (32'd1 << (13 + dv)) | (32'(dv) << 8) | 32'(off & 8'hFC);
        ew = 32'hB7E1_5163 ^ 32'(dv);
        run_req(a, 1'b1, ew, 2'(sz), 1, -1);
        if (sz == 2) begin
          chk("R3 full config write single cycle", 32'(n_txn), 32'd1);
          chk("R3 config write command", {28'd0, t_cmd[0]}, 32'hB);
          chk("R3 config write data", t_wdata[0], ew);
        end else begin
          m  = bmask(exp_lanes(2'(sz), off[1:0]));
          er = (resp_of(ea) & ~m) | ((ew << (8 * off[1:0])) & m);
          chk("R6 two cycles", 32'(n_txn), 32'd2);
          chk("R6 read phase command", {28'd0, t_cmd[0]}, 32'hA);
          chk("R6 write phase command", {28'd0, t_cmd[1]}, 32'hB);
          chk("R6 same address", t_addr[1], ea);
          chk("R6 write phase enables", {28'd0, t_be[1]}, 32'hF);
          chk("R6 merged word", t_wdata[1], er);
        end
        chk("R6 config write no error", {31'd0, r_err}, 32'd0);
      end
    end

    // R7: aborts and the sticky flag
    run_req(32'h8000_0100 | (32'd2 << 11), 1'b1, 32'h0000_00AB, 2'd0, 0, 0);
    chk("R6 abort on read phase skips write", 32'(n_txn), 32'd1);
    chk("R7 config abort error", {31'd0, r_err}, 32'd1);
    chk("R7 flag set by abort", {31'd0, abort_flag}, 32'd1);
    reg_wr(1'b1, 32'hFBFF_FFFF);
    chk("R7 write without bit 26 keeps flag", {31'd0, abort_flag}, 32'd1);
    reg_wr(1'b1, 32'h0400_0000);
    chk("R7 write with bit 26 clears flag", {31'd0, abort_flag}, 32'd0);
    reg_wr(1'b0, 32'h0000_000C);
    run_req(32'h8765_4320, 1'b0, '0, 2'd2, 2, 0);
    chk("R7 memory read abort error", {31'd0, r_err}, 32'd1);
    chk("R7 memory read abort all ones", r_data, 32'hFFFF_FFFF);
    chk("R7 flag set again", {31'd0, abort_flag}, 32'd1);
    run_req(32'h8765_4324, 1'b1, 32'h55AA_55AA, 2'd2, 0, 0);
    chk("R7 memory write abort error", {31'd0, r_err}, 32'd1);
    reg_wr(1'b1, 32'h0400_0000);
    chk("R7 cleared", {31'd0, abort_flag}, 32'd0);

    // R8: reset pin modes
    for (int pm = 0; pm < 4; pm++) begin
      reg_wr(1'b0, 32'(pm) << 4);
      chk("R8 pin output enable", {31'd0, rst_pin_oe}, (pm == 1 || pm == 2) ? 32'd1 : 32'd0);
      if (pm == 1 || pm == 2)
        chk("R8 pin level", {31'd0, rst_pin}, (pm == 2) ? 32'd1 : 32'd0);
    end

    // R10: reset in the middle of use returns to the initial state
    reg_wr(1'b0, 32'h0000_0022);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 pin back to input", {31'd0, rst_pin_oe}, 32'd0);
    rst_n = 1'b1;
    run_req(32'hA000_0040, 1'b0, '0, 2'd2, 0, -1);
    chk("R10 memory mode after reset", {28'd0, t_cmd[0]}, 32'h6);
    chk("R10 upper bits after reset", t_addr[0], 32'h2000_0040);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule